// File: doc/BRIEF.md
# Serial Peripheral Pause Gate

This block sits between the raw pins of a serial peripheral slave and the slave's shift core. It implements the pause feature driven by an active-low hold pin. It samples chip-select, serial clock and hold with a faster system clock through a synchroniser. From these samples it produces single-cycle strobes that tell the core when the serial clock rose or fell. It also produces a hold flag, an enable for the serial data output driver, and a request that resets the core's interface logic.

A pause starts or ends only while the serial clock is low. A hold edge that arrives while the clock is high is parked in a pending state until the clock drops. While a pause is in force, the core gets no clock strobes and the data output is released to high impedance, so the core's shift state stays frozen. Releasing chip-select in the middle of a pause latches a reset request. The request stays up until chip-select is asserted again while the hold pin is high. Internal write or erase cycles are not routed through this block, so a pause leaves them running.

Top module: `hold_gate`

## Requirements
- R1: After reset, hold_active, core_reset, so_oe, sck_rise_en and sck_fall_en are all 0.
- R2: With chip-select low and the serial clock low, a falling edge on the hold pin sets hold_active.
- R3: A falling hold edge seen while the serial clock is high leaves hold_active at 0 until the clock falls, and then sets it. If the hold pin returns high before that, the pending entry is dropped.
- R4: A rising hold edge during a pause clears hold_active at once if the serial clock is low. If the clock is high, hold_active stays 1 until the clock falls. If the hold pin goes low again before that, the pending exit is dropped and the pause continues.
- R5: Hold edges while chip-select is high have no effect. Lowering chip-select while the hold pin is already low does not start a pause.
- R6: Each serial clock rising edge gives exactly one sck_rise_en pulse, and each falling edge gives one sck_fall_en pulse. This applies only while chip-select is low, no pause is in force and core_reset is 0. The clock fall that completes a deferred entry or a deferred exit gives no pulse.
- R7: so_oe follows so_drive while chip-select is low, no pause is in force and core_reset is 0. Otherwise so_oe is 0.
- R8: Chip-select rising while hold_active is 1 sets core_reset. Chip-select rising while only an entry is pending does not.
- R9: core_reset stays 1 until chip-select falls while the hold pin is high. A chip-select fall with the hold pin low keeps it at 1, and during that time no pause can start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_pin | input | 1 | Raw chip-select, active low |
| sck_pin | input | 1 | Raw serial clock |
| hold_n_pin | input | 1 | Raw hold request, active low |
| so_drive | input | 1 | Core wants to drive the data output |
| hold_active | output | 1 | Pause in force |
| sck_rise_en | output | 1 | One-cycle strobe for a qualified clock rise |
| sck_fall_en | output | 1 | One-cycle strobe for a qualified clock fall |
| so_oe | output | 1 | Data output driver enable |
| core_reset | output | 1 | Reset request for the core's interface logic |

## Verification
The bench builds the block with the default two-stage synchroniser. The pin-to-output latency is then three system clocks, well inside the eight-cycle settle window the bench leaves after each pin change. Because only one pin moves per step, every deferred entry, deferred exit, cancelled pending state and locked-out reset path is reached in isolation, both by the directed sequences and by the biased random walk. Strobe counts are compared against a step-level reference, so a lost or extra clock pulse shows up as a count mismatch.

// File: rtl/hold_gate_pkg.sv
package hold_gate_pkg;

    typedef struct packed {
        logic cs_n;
        logic sck;
        logic hold_n;
    } pins_t;

    localparam int PIN_COUNT = $bits(pins_t);

    localparam pins_t PINS_IDLE = '{cs_n: 1'b1, sck: 1'b0, hold_n: 1'b1};

    typedef enum logic [1:0] {
        PS_RUN      = 2'd0,
        PS_WAIT_IN  = 2'd1,
        PS_HELD     = 2'd2,
        PS_WAIT_OUT = 2'd3
    } pause_st_e;

    typedef struct packed {
        logic cs_rise;
        logic cs_fall;
        logic sck_rise;
        logic sck_fall;
        logic hold_rise;
        logic hold_fall;
    } edges_t;

    function automatic logic is_paused(pause_st_e st);
        return (st == PS_HELD) || (st == PS_WAIT_OUT);
    endfunction

    function automatic edges_t find_edges(pins_t now, pins_t prev);
        edges_t e;
        e.cs_rise   =  now.cs_n   & ~prev.cs_n;
        e.cs_fall   = ~now.cs_n   &  prev.cs_n;
        e.sck_rise  =  now.sck    & ~prev.sck;
        e.sck_fall  = ~now.sck    &  prev.sck;
        e.hold_rise =  now.hold_n & ~prev.hold_n;
        e.hold_fall = ~now.hold_n &  prev.hold_n;
        return e;
    endfunction

endpackage

// File: rtl/hold_pin_sync.sv
module hold_pin_sync
    import hold_gate_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  pins_t raw,
    output pins_t now,
    output pins_t prev
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [PIN_COUNT-1:0] raw_v;
    logic [PIN_COUNT-1:0] idle_v;
    logic [PIN_COUNT-1:0] now_v;
    logic [PIN_COUNT-1:0] prev_v;

    assign raw_v  = raw;
    assign idle_v = PINS_IDLE;

    for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
        logic [SYNC_STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) begin
                chain <= {SYNC_STAGES{idle_v[p]}};
            end else if (SYNC_STAGES == 1) begin
                chain[0] <= raw_v[p];
            end else begin
                chain <= {chain[SYNC_STAGES-2:0], raw_v[p]};
            end
        end
        assign now_v[p] = chain[LAST];
    end

    always_ff @(posedge clk) begin
        if (rst) prev_v <= idle_v;
        else     prev_v <= now_v;
    end

    assign now  = pins_t'(now_v);
    assign prev = pins_t'(prev_v);
endmodule

// File: rtl/hold_pause_fsm.sv
module hold_pause_fsm
    import hold_gate_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  pins_t     now,
    input  pins_t     prev,
    output pause_st_e st,
    output pause_st_e st_next,
    output logic      lock,
    output logic      lock_next
);
    edges_t e;
    assign e = find_edges(now, prev);

    always_comb begin
        lock_next = lock;
        if (lock) begin
            if (e.cs_fall && now.hold_n) lock_next = 1'b0;
        end else if (now.cs_n && is_paused(st)) begin
            lock_next = 1'b1;
        end
    end

    always_comb begin
        st_next = st;
        if (now.cs_n || lock_next) begin
            st_next = PS_RUN;
        end else begin
            unique case (st)
                PS_RUN: begin
                    if (e.hold_fall) st_next = now.sck ? PS_WAIT_IN : PS_HELD;
                end
                PS_WAIT_IN: begin
                    if (now.hold_n)    st_next = PS_RUN;
                    else if (!now.sck) st_next = PS_HELD;
                end
                PS_HELD: begin
                    if (e.hold_rise) st_next = now.sck ? PS_WAIT_OUT : PS_RUN;
                end
                PS_WAIT_OUT: begin
                    if (!now.hold_n)   st_next = PS_HELD;
                    else if (!now.sck) st_next = PS_RUN;
                end
                default: st_next = PS_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= PS_RUN;
            lock <= 1'b0;
        end else begin
            st   <= st_next;
            lock <= lock_next;
        end
    end
endmodule

// File: rtl/hold_out_gate.sv
module hold_out_gate
    import hold_gate_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  pins_t     now,
    input  pins_t     prev,
    input  pause_st_e st,
    input  pause_st_e st_next,
    input  logic      lock,
    input  logic      lock_next,
    input  logic      so_drive,
    output logic      rise_en,
    output logic      fall_en,
    output logic      oe
);
    edges_t e;
    logic   quiet;
    logic   oe_block;

    assign e = find_edges(now, prev);

    // A clock edge is withheld if a pause holds on either side of the sample.
    assign quiet    = now.cs_n | is_paused(st) | is_paused(st_next) | lock | lock_next;
    assign oe_block = now.cs_n | is_paused(st_next) | lock_next;

    always_ff @(posedge clk) begin
        if (rst) begin
            rise_en <= 1'b0;
            fall_en <= 1'b0;
            oe      <= 1'b0;
        end else begin
            rise_en <= e.sck_rise & ~quiet;
            fall_en <= e.sck_fall & ~quiet;
            oe      <= so_drive & ~oe_block;
        end
    end
endmodule

// File: rtl/hold_gate.sv
module hold_gate
    import hold_gate_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n_pin,
    input  logic sck_pin,
    input  logic hold_n_pin,
    input  logic so_drive,
    output logic hold_active,
    output logic sck_rise_en,
    output logic sck_fall_en,
    output logic so_oe,
    output logic core_reset
);
    pins_t     raw;
    pins_t     now;
    pins_t     prev;
    pause_st_e st;
    pause_st_e st_next;
    logic      lock;
    logic      lock_next;

    assign raw = '{cs_n: cs_n_pin, sck: sck_pin, hold_n: hold_n_pin};

    hold_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .raw  (raw),
        .now  (now),
        .prev (prev)
    );

    hold_pause_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .now       (now),
        .prev      (prev),
        .st        (st),
        .st_next   (st_next),
        .lock      (lock),
        .lock_next (lock_next)
    );

    hold_out_gate u_gate (
        .clk       (clk),
        .rst       (rst),
        .now       (now),
        .prev      (prev),
        .st        (st),
        .st_next   (st_next),
        .lock      (lock),
        .lock_next (lock_next),
        .so_drive  (so_drive),
        .rise_en   (sck_rise_en),
        .fall_en   (sck_fall_en),
        .oe        (so_oe)
    );

    assign hold_active = is_paused(st);
    assign core_reset  = lock;
endmodule

// File: rtl/hold_gate_chk.sv
module hold_gate_chk (
    input logic clk,
    input logic rst,
    input logic hold_active,
    input logic sck_rise_en,
    input logic sck_fall_en,
    input logic so_oe,
    input logic core_reset
);
    // R6: no clock strobe reaches the core while paused
    a_r6_no_strobe_in_pause: assert property (@(posedge clk) disable iff (rst)
        hold_active |-> (!sck_rise_en && !sck_fall_en));

    // R6: the two strobes never fire together
    a_r6_one_strobe: assert property (@(posedge clk) disable iff (rst)
        !(sck_rise_en && sck_fall_en));

    // R7: the output driver is released during a pause
    a_r7_oe_off_in_pause: assert property (@(posedge clk) disable iff (rst)
        hold_active |-> !so_oe);

    // R9: a pending reset silences the core side
    a_r9_reset_quiets: assert property (@(posedge clk) disable iff (rst)
        core_reset |-> (!so_oe && !sck_rise_en && !sck_fall_en && !hold_active));

    // R8: a reset request only appears out of a pause
    a_r8_reset_from_pause: assert property (@(posedge clk) disable iff (rst)
        $rose(core_reset) |-> $past(hold_active));
endmodule

bind hold_gate hold_gate_chk u_chk (.*);

// File: tb/tb_hold_gate.sv
module tb_hold_gate;
    localparam int SETTLE = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n_pin = 1'b1;
    logic sck_pin = 1'b0;
    logic hold_n_pin = 1'b1;
    logic so_drive = 1'b0;
    logic hold_active, sck_rise_en, sck_fall_en, so_oe, core_reset;

    always #2 clk = ~clk;

    hold_gate dut (
        .clk(clk), .rst(rst), .cs_n_pin(cs_n_pin), .sck_pin(sck_pin),
        .hold_n_pin(hold_n_pin), .so_drive(so_drive),
        .hold_active(hold_active), .sck_rise_en(sck_rise_en),
        .sck_fall_en(sck_fall_en), .so_oe(so_oe), .core_reset(core_reset)
    );

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    int got_r = 0;
    int got_f = 0;

    always @(posedge clk) begin
        if (rst) begin
            got_r <= 0;
            got_f <= 0;
        end else begin
            if (sck_rise_en) got_r <= got_r + 1;
            if (sck_fall_en) got_f <= got_f + 1;
        end
    end

    // reference: 0 run, 1 wait-in, 2 held, 3 wait-out
    int m_st = 0;
    bit m_lock = 1'b0;
    int exp_r = 0;
    int exp_f = 0;

    function automatic bit m_paused(int s);
        return (s == 2) || (s == 3);
    endfunction

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all();
        check("R3 hold_active", int'(hold_active), int'(m_paused(m_st)));
        check("R9 core_reset", int'(core_reset), int'(m_lock));
        check("R7 so_oe", int'(so_oe),
              int'(so_drive && !cs_n_pin && !m_paused(m_st) && !m_lock));
        check("R6 rise count", got_r, exp_r);
        check("R6 fall count", got_f, exp_f);
    endtask

    // which: 0 cs, 1 sck, 2 hold
    task automatic step(int which, bit val);
        @(negedge clk);
        case (which)
            0: begin
                if (val && !cs_n_pin) begin
                    if (m_paused(m_st)) m_lock = 1'b1;
                    m_st = 0;
                end else if (!val && cs_n_pin) begin
                    if (m_lock && hold_n_pin) m_lock = 1'b0;
                end
                cs_n_pin = val;
            end
            1: begin
                if (val != sck_pin) begin
                    if (cs_n_pin || m_lock) begin
                        // no effect
                    end else if (val) begin
                        if (!m_paused(m_st)) exp_r++;
                    end else begin
                        if (m_st == 1)      m_st = 2;
                        else if (m_st == 3) m_st = 0;
                        else if (m_st == 0) exp_f++;
                    end
                end
                sck_pin = val;
            end
            default: begin
                if (val != hold_n_pin && !cs_n_pin && !m_lock) begin
                    if (!val) begin
                        if (m_st == 0)      m_st = sck_pin ? 1 : 2;
                        else if (m_st == 3) m_st = 2;
                    end else begin
                        if (m_st == 1)      m_st = 0;
                        else if (m_st == 2) m_st = sck_pin ? 3 : 0;
                    end
                end
                hold_n_pin = val;
            end
        endcase
        repeat (SETTLE) @(negedge clk);
        check_all();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 hold_active", int'(hold_active), 0);
        check("R1 core_reset", int'(core_reset), 0);
        check("R1 so_oe", int'(so_oe), 0);
        check("R1 strobes", got_r + got_f, 0);

        so_drive = 1'b1;
        // R2 entry with clock low, then frozen clock, then R4 immediate exit
        step(0, 1'b0);
        check("R7 so_oe active", int'(so_oe), 1);
        step(1, 1'b1); step(1, 1'b0);
        step(2, 1'b0);
        check("R2 pause entered", int'(hold_active), 1);
        step(1, 1'b1); step(1, 1'b0);
        check("R6 frozen rises", got_r, 1);
        step(2, 1'b1);
        check("R4 exit clock low", int'(hold_active), 0);

        // R3 deferred entry and cancelled entry
        step(1, 1'b1);
        step(2, 1'b0);
        check("R3 entry deferred", int'(hold_active), 0);
        step(1, 1'b0);
        check("R3 entry on clock fall", int'(hold_active), 1);
        check("R6 completing fall withheld", got_f, 1);
        step(2, 1'b1);
        step(1, 1'b1);
        step(2, 1'b0); step(2, 1'b1);
        step(1, 1'b0);
        check("R3 cancelled entry", int'(hold_active), 0);

        // R4 deferred exit and cancelled exit
        step(2, 1'b0);
        step(1, 1'b1);
        step(2, 1'b1);
        check("R4 exit deferred", int'(hold_active), 1);
        step(2, 1'b0);
        step(1, 1'b0);
        check("R4 cancelled exit", int'(hold_active), 1);
        step(1, 1'b1);
        step(2, 1'b1);
        step(1, 1'b0);
        check("R4 exit on clock fall", int'(hold_active), 0);

        // R5 ignored while deselected
        step(0, 1'b1);
        step(2, 1'b0);
        check("R5 edge while deselected", int'(hold_active), 0);
        step(0, 1'b0);
        check("R5 select with hold low", int'(hold_active), 0);
        step(2, 1'b1);

        // R8 pending entry release gives no reset
        step(1, 1'b1);
        step(2, 1'b0);
        step(0, 1'b1);
        check("R8 no reset from pending", int'(core_reset), 0);
        step(2, 1'b1); step(1, 1'b0); step(0, 1'b0);

        // R8 and R9 release during pause
        step(2, 1'b0);
        step(0, 1'b1);
        check("R8 reset raised", int'(core_reset), 1);
        step(0, 1'b0);
        check("R9 held by low hold", int'(core_reset), 1);
        step(1, 1'b1); step(1, 1'b0);
        check("R9 no strobes while locked", got_r, exp_r);
        step(2, 1'b1);
        step(2, 1'b0);
        check("R9 no pause while locked", int'(hold_active), 0);
        step(2, 1'b1);
        step(0, 1'b1);
        step(0, 1'b0);
        check("R9 reset cleared", int'(core_reset), 0);

        // random walk
        for (int i = 0; i < 400; i++) begin
            int pick;
            pick = int'($urandom_range(0, 9));
            so_drive = 1'($urandom_range(0, 1));
            if (pick == 0)      step(0, ~cs_n_pin);
            else if (pick < 6)  step(1, ~sck_pin);
            else                step(2, ~hold_n_pin);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule